// File: doc/BRIEF.md
# UART Bit-Rate Generator

This block sets the bit timing of a serial port. A reference clock, optionally slowed by a fixed divide-by-8 prescaler, drives a programmable generator counter. The counter emits a one-cycle sample tick every generator-value input periods. A second counter counts these ticks and emits a bit strobe once every divisor-plus-one ticks. The resulting bit rate is the selected clock divided by the product of the generator value and the divisor plus one.

Software programs three registers through a simple write port: a mode register whose bit 0 turns on the prescaler, a 16-bit generator register and an 8-bit bit-divisor register. A write below a register's legal minimum is dropped, and the register keeps its previous value. Every accepted write restarts the prescaler and both counters from zero, so no partial period is ever produced.

A small sequencer has two states. In `SEQ_FLUSH` the counters are held. In `SEQ_RUN` they advance. Reset enters `SEQ_FLUSH`. The transition *start* moves from `SEQ_FLUSH` to `SEQ_RUN` on the first clock edge without an accepted write. The transition *restart* moves from either state back to `SEQ_FLUSH` on any accepted write.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the generator value is 0x28B, the divisor value is 0x0F and the prescaler is off, and the tick schedule then follows R8 as if a write had been accepted on the edge before reset release.
- R2: Writes decode the full byte address. Address 0x04 is the mode register (only bit 0 is stored), 0x18 is the generator register and 0x34 is the divisor register. A write to any other address changes no register and does not disturb the tick schedule.
- R3: A write to 0x18 is dropped when the full 32-bit value is 0. Otherwise the low 16 bits are stored. A stored 0 acts as a period of 65536.
- R4: A write to 0x34 is dropped when the full 32-bit value is below 4. Otherwise the low 8 bits are stored, so a truncated value such as 0 is possible.
- R5: With mode bit 0 set, the generator advances once every 8 clock cycles. With it clear, the generator advances every cycle.
- R6: `sample_tick` is a one-cycle pulse repeating every P*G cycles, where P is 8 or 1 (per R5) and G is the stored generator value.
- R7: `bit_strobe` repeats every D+1 sample ticks, where D is the stored divisor value, and is high only in a cycle where `sample_tick` is also high.
- R8: Counting the write edge as edge 0, an accepted write gives no tick or strobe before edge P*G+1. The first tick is visible after edge P*G+1, and the first strobe after edge P*G*(D+1)+1.
- R9: A dropped write (R3, R4) leaves the running tick and strobe schedule unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 8 | Byte address of the write |
| cfg_wdata | input | 32 | Write data |
| sample_tick | output | 1 | One-cycle pulse at the generator rate |
| bit_strobe | output | 1 | One-cycle pulse once per bit period |
| gen_value | output | 16 | Stored generator value |
| div_value | output | 8 | Stored divisor value |
| prescale_on | output | 1 | Stored prescaler enable (mode bit 0) |

## Verification
Register contents are due one cycle after the write edge, and the bench reads them at the falling edge that follows. Tick and strobe timing is indexed from the falling edge after the accepted write, or after reset release. At index k, a tick is expected when k-1 is a positive multiple of P*G, and a strobe when k-1 is a positive multiple of P*G*(D+1). Every falling edge of a window covering two full bit periods is compared against this formula. Dropped or unmapped writes are injected in the middle of such a window, with the same expected schedule kept.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

    typedef enum logic [0:0] {
        SEQ_FLUSH = 1'b0,
        SEQ_RUN   = 1'b1
    } seq_state_t;

    localparam int CFG_ADDR_W   = 8;
    localparam int CFG_DATA_W   = 32;
    localparam int GEN_WIDTH    = 16;
    localparam int DIV_WIDTH    = 8;
    localparam int PRE_RATIO    = 8;
    localparam int GEN_MIN      = 1;
    localparam int DIV_MIN      = 4;
    localparam int GEN_RESET    = 'h28B;
    localparam int DIV_RESET    = 'hF;

    localparam logic [CFG_ADDR_W-1:0] ADDR_MODE = 8'h04;
    localparam logic [CFG_ADDR_W-1:0] ADDR_GEN  = 8'h18;
    localparam logic [CFG_ADDR_W-1:0] ADDR_DIV  = 8'h34;

endpackage

// File: rtl/baud_cfg_regs.sv
module baud_cfg_regs #(
    parameter int ADDR_W   = baud_gen_pkg::CFG_ADDR_W,
    parameter int DATA_W   = baud_gen_pkg::CFG_DATA_W,
    parameter int GEN_W    = baud_gen_pkg::GEN_WIDTH,
    parameter int DIV_W    = baud_gen_pkg::DIV_WIDTH,
    parameter int GEN_MIN  = baud_gen_pkg::GEN_MIN,
    parameter int DIV_MIN  = baud_gen_pkg::DIV_MIN,
    parameter int GEN_RST  = baud_gen_pkg::GEN_RESET,
    parameter int DIV_RST  = baud_gen_pkg::DIV_RESET
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [GEN_W-1:0]  gen_q,
    output logic [DIV_W-1:0]  div_q,
    output logic              pre_q,
    output logic              accept
);
    import baud_gen_pkg::*;

    localparam logic [DATA_W-1:0] GEN_FLOOR = DATA_W'(GEN_MIN);
    localparam logic [DATA_W-1:0] DIV_FLOOR = DATA_W'(DIV_MIN);

    logic hit_mode;
    logic hit_gen;
    logic hit_div;
    logic take_gen;
    logic take_div;

    always_comb begin
        hit_mode = we && (addr == ADDR_MODE);
        hit_gen  = we && (addr == ADDR_GEN);
        hit_div  = we && (addr == ADDR_DIV);
        take_gen = hit_gen && (wdata >= GEN_FLOOR);
        take_div = hit_div && (wdata >= DIV_FLOOR);
        accept   = hit_mode || take_gen || take_div;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_q <= GEN_W'(GEN_RST);
            div_q <= DIV_W'(DIV_RST);
            pre_q <= 1'b0;
        end else begin
            if (hit_mode) begin
                pre_q <= wdata[0];
            end
            if (take_gen) begin
                gen_q <= wdata[GEN_W-1:0];
            end
            if (take_div) begin
                div_q <= wdata[DIV_W-1:0];
            end
        end
    end

endmodule

// File: rtl/baud_seq_fsm.sv
module baud_seq_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic run
);
    import baud_gen_pkg::*;

    seq_state_t state_q;
    seq_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_FLUSH: state_d = restart ? SEQ_FLUSH : SEQ_RUN;
            SEQ_RUN:   state_d = restart ? SEQ_FLUSH : SEQ_RUN;
            default:   state_d = SEQ_FLUSH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_FLUSH;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            SEQ_FLUSH: run = 1'b0;
            SEQ_RUN:   run = !restart;
            default:   run = 1'b0;
        endcase
    end

endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
    parameter int RATIO = baud_gen_pkg::PRE_RATIO
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic pre_on,
    output logic step
);
    generate
        if (RATIO > 1) begin : g_div
            localparam int PW = $clog2(RATIO);
            localparam logic [PW-1:0] LAST = PW'(RATIO - 1);
            logic [PW-1:0] cnt_q;
            logic          at_last;

            assign at_last = (cnt_q == LAST);

            always_ff @(posedge clk) begin
                if (!rst_n || clear) begin
                    cnt_q <= '0;
                end else if (run) begin
                    cnt_q <= at_last ? '0 : cnt_q + PW'(1);
                end
            end

            assign step = run && (!pre_on || at_last);
        end else begin : g_pass
            logic unused_sig;
            assign unused_sig = clk ^ rst_n ^ clear ^ pre_on;
            assign step = run;
        end
    endgenerate

endmodule

// File: rtl/baud_stage_counter.sv
module baud_stage_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         adv,
    input  logic [W-1:0] last,
    output logic         wrap
);
    logic [W-1:0] cnt_q;

    assign wrap = adv && (cnt_q == last);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= wrap ? '0 : cnt_q + W'(1);
        end
    end

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
    parameter int ADDR_W    = baud_gen_pkg::CFG_ADDR_W,
    parameter int DATA_W    = baud_gen_pkg::CFG_DATA_W,
    parameter int GEN_W     = baud_gen_pkg::GEN_WIDTH,
    parameter int DIV_W     = baud_gen_pkg::DIV_WIDTH,
    parameter int PRE_RATIO = baud_gen_pkg::PRE_RATIO
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              sample_tick,
    output logic              bit_strobe,
    output logic [GEN_W-1:0]  gen_value,
    output logic [DIV_W-1:0]  div_value,
    output logic              prescale_on
);
    logic             restart;
    logic             run;
    logic             pre_step;
    logic             gen_wrap;
    logic             div_wrap;
    logic [GEN_W-1:0] gen_last;
    logic             tick_q;
    logic             strobe_q;

    baud_cfg_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .GEN_W  (GEN_W),
        .DIV_W  (DIV_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .gen_q  (gen_value),
        .div_q  (div_value),
        .pre_q  (prescale_on),
        .accept (restart)
    );

    baud_seq_fsm u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .run     (run)
    );

    baud_prescaler #(
        .RATIO (PRE_RATIO)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (restart),
        .run    (run),
        .pre_on (prescale_on),
        .step   (pre_step)
    );

    assign gen_last = gen_value - GEN_W'(1);

    baud_stage_counter #(
        .W (GEN_W)
    ) u_gen_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (restart),
        .adv   (pre_step),
        .last  (gen_last),
        .wrap  (gen_wrap)
    );

    baud_stage_counter #(
        .W (DIV_W)
    ) u_div_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (restart),
        .adv   (gen_wrap),
        .last  (div_value),
        .wrap  (div_wrap)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q   <= 1'b0;
            strobe_q <= 1'b0;
        end else begin
            tick_q   <= gen_wrap && !restart;
            strobe_q <= div_wrap && !restart;
        end
    end

    assign sample_tick = tick_q;
    assign bit_strobe  = strobe_q;

endmodule

// File: rtl/baud_tick_gen_checker.sv
module baud_tick_gen_checker #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int GEN_W  = 16,
    parameter int DIV_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [DATA_W-1:0] cfg_wdata,
    input logic              sample_tick,
    input logic              bit_strobe,
    input logic [GEN_W-1:0]  gen_value,
    input logic [DIV_W-1:0]  div_value,
    input logic              prescale_on
);
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(8'h04);
    localparam logic [ADDR_W-1:0] A_GEN  = ADDR_W'(8'h18);
    localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(8'h34);

    assert_strobe_with_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe |-> sample_tick);

    assert_tick_single_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_tick && (gen_value != GEN_W'(1) || prescale_on) |=> !sample_tick);

    assert_gen_zero_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_addr == A_GEN && cfg_wdata == '0 |=> $stable(gen_value));

    assert_div_small_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_addr == A_DIV && cfg_wdata < DATA_W'(4) |=> $stable(div_value));

    assert_restart_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_addr == A_MODE |=> !sample_tick && !bit_strobe);

    assert_unmapped_no_effect_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_addr != A_MODE && cfg_addr != A_GEN && cfg_addr != A_DIV
        |=> $stable(gen_value) && $stable(div_value) && $stable(prescale_on));

endmodule

bind baud_tick_gen baud_tick_gen_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .GEN_W  (GEN_W),
    .DIV_W  (DIV_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .sample_tick (sample_tick),
    .bit_strobe  (bit_strobe),
    .gen_value   (gen_value),
    .div_value   (div_value),
    .prescale_on (prescale_on)
);

// File: tb/baud_tick_gen_bench.sv
module baud_tick_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [31:0] cfg_wdata = 32'h0;
    logic        sample_tick;
    logic        bit_strobe;
    logic [15:0] gen_value;
    logic [7:0]  div_value;
    logic        prescale_on;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    baud_tick_gen u_baud_tick_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .sample_tick (sample_tick),
        .bit_strobe  (bit_strobe),
        .gen_value   (gen_value),
        .div_value   (div_value),
        .prescale_on (prescale_on)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Index 0 is the current falling edge; compares every falling edge 1..n.
    task automatic run_window(input int p, input int g, input int d, input int n,
                              input int inj_k, input logic [7:0] inj_a,
                              input logic [31:0] inj_d, input string req);
        int per_t;
        int per_s;
        int bad_t;
        int bad_s;
        int first_t;
        int first_s;
        int ticks;
        per_t = p * g;
        per_s = p * g * (d + 1);
        bad_t = 0;
        bad_s = 0;
        first_t = -1;
        first_s = -1;
        ticks = 0;
        for (int k = 1; k <= n; k++) begin
            bit et;
            bit es;
            @(negedge clk);
            if (k == inj_k + 1) cfg_we = 1'b0;
            et = (k > 1) && ((k - 1) % per_t == 0);
            es = (k > 1) && ((k - 1) % per_s == 0);
            if (sample_tick) ticks++;
            if (sample_tick !== et) begin
                bad_t++;
                if (first_t < 0) first_t = k;
            end
            if (bit_strobe !== es) begin
                bad_s++;
                if (first_s < 0) first_s = k;
            end
            if (k == inj_k) begin
                cfg_we    = 1'b1;
                cfg_addr  = inj_a;
                cfg_wdata = inj_d;
            end
        end
        check(bad_t == 0, req, $sformatf("tick schedule p%0d g%0d d%0d mismatches (first at %0d)",
              p, g, d, first_t), bad_t, 0);
        check(bad_s == 0, req, $sformatf("strobe schedule p%0d g%0d d%0d mismatches (first at %0d)",
              p, g, d, first_s), bad_s, 0);
        check(ticks == (n - 1) / per_t, req, "tick count", ticks, (n - 1) / per_t);
    endtask

    task automatic setup(input int p, input int g, input int d);
        cfg_write(8'h04, p == 8 ? 32'h1 : 32'h0);
        cfg_write(8'h18, g);
        cfg_write(8'h34, d);
    endtask

    initial begin
        int gs[4];
        int ds[3];
        gs = '{1, 2, 3, 5};
        ds = '{4, 5, 7};

        repeat (3) @(negedge clk);
        // R1: reset state
        check(gen_value == 16'h28B, "R1", "reset generator", gen_value, 32'h28B);
        check(div_value == 8'h0F, "R1", "reset divisor", div_value, 32'hF);
        check(prescale_on == 1'b0, "R1", "reset prescale", prescale_on, 0);
        check(!sample_tick && !bit_strobe, "R1", "outputs low in reset",
              {sample_tick, bit_strobe}, 0);
        rst_n = 1'b1;
        // R1 R8: schedule from reset release, two bit periods
        run_window(1, 651, 15, 2 * 651 * 16 + 2, -1, 8'h00, 0, "R1");

        // R5 R6 R7 R8: sweep of small configurations, prescale on and off
        foreach (gs[i]) begin
            foreach (ds[j]) begin
                for (int pm = 0; pm < 2; pm++) begin
                    int p;
                    p = (pm == 1) ? 8 : 1;
                    setup(p, gs[i], ds[j]);
                    run_window(p, gs[i], ds[j], 2 * p * gs[i] * (ds[j] + 1) + 2,
                               -1, 8'h00, 0, pm == 1 ? "R5" : "R6");
                end
            end
        end

        // R3: generator write rules
        cfg_write(8'h18, 32'h0001_2345);
        check(gen_value == 16'h2345, "R3", "generator truncation", gen_value, 32'h2345);
        cfg_write(8'h18, 32'h0);
        check(gen_value == 16'h2345, "R3", "zero write dropped", gen_value, 32'h2345);
        cfg_write(8'h18, 32'h0001_0000);
        check(gen_value == 16'h0000, "R3", "truncated to zero", gen_value, 0);

        // R4: divisor write rules
        cfg_write(8'h34, 32'h6);
        cfg_write(8'h34, 32'h3);
        check(div_value == 8'h06, "R4", "value 3 dropped", div_value, 6);
        cfg_write(8'h34, 32'h1FF);
        check(div_value == 8'hFF, "R4", "divisor truncation", div_value, 32'hFF);
        cfg_write(8'h34, 32'h4);
        check(div_value == 8'h04, "R4", "minimum 4 stored", div_value, 4);

        // R2: mode bit 0 only, unmapped address ignored
        cfg_write(8'h04, 32'hFFFF_FFFE);
        check(prescale_on == 1'b0, "R2", "mode bit0 clear", prescale_on, 0);
        cfg_write(8'h04, 32'h0000_0001);
        check(prescale_on == 1'b1, "R2", "mode bit0 set", prescale_on, 1);
        cfg_write(8'h30, 32'h0000_0005);
        check(gen_value == 16'h0 && div_value == 8'h4 && prescale_on,
              "R2", "unmapped write", {gen_value, div_value, 7'd0, prescale_on},
              {16'h0, 8'h4, 8'h1});

        // R4 R7: truncated divisor of 0 strobes on every tick
        setup(1, 2, 32'h100);
        check(div_value == 8'h00, "R4", "0x100 stores 0", div_value, 0);
        run_window(1, 2, 0, 12, -1, 8'h00, 0, "R7");

        // R9: dropped writes mid-stream leave the schedule intact
        setup(1, 3, 4);
        run_window(1, 3, 4, 40, 10, 8'h18, 32'h0, "R9");
        setup(1, 3, 4);
        run_window(1, 3, 4, 40, 7, 8'h34, 32'h2, "R9");
        // R2: unmapped write mid-stream leaves the schedule intact
        setup(8, 1, 4);
        run_window(8, 1, 4, 90, 13, 8'h30, 32'h7, "R2");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule